// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block runs one access to a register inside a remote management device that exposes only two registers: a command register and a data register. The host supplies the remote device's strapped bus address, the internal device number, the internal register number, a read/write flag and write data. The block turns that into a short chain of primitive register transfers on a simple request/acknowledge port. A serial management bus master, which is not part of this block, serves that port. The block returns the read data or an error code.

A read writes the command word, polls the command register until its busy bit (bit 15) reads 0, then reads the data register. A write loads the data register first, then writes the command word, then polls the busy bit. Polling has a time budget counted in clock cycles and derived from the clock-frequency parameter. The budget never cuts polling short of a minimum number of attempts. The first attempts run back to back. Later attempts are spaced by a gap of about one millisecond. After reset, the block polls the remote busy bit at a fixed address before it takes its first request.

States: ST_POLL (poll read), ST_GAP (wait between polls), ST_IDLE, ST_PUT_DATA (data register write), ST_PUT_CMD (command register write), ST_GET_DATA (data register read) and ST_FINISH (one-cycle result). Transitions: reset→ST_POLL (init pass); ST_POLL→ST_POLL (back-to-back retry); ST_POLL→ST_GAP (busy after the minimum attempts); ST_GAP→ST_POLL (gap over, budget left); ST_GAP→ST_FINISH (timeout); ST_POLL→ST_IDLE (init done); ST_POLL→ST_GET_DATA (read, busy clear); ST_POLL→ST_FINISH (write, busy clear); ST_IDLE→ST_PUT_DATA (write); ST_IDLE→ST_PUT_CMD (read); ST_PUT_DATA→ST_PUT_CMD; ST_PUT_CMD→ST_POLL; ST_GET_DATA→ST_FINISH; any access with an error→ST_FINISH; ST_FINISH→ST_IDLE.

Top module: `ias_seq`

## Requirements
- R1: After reset, req_ready is 0. The block repeatedly reads register 0 at address INIT_ADDR until a read returns bit 15 = 0. It then raises req_ready. This init pass never pulses done.
- R2: A read request produces, in order, a write of register 0 (command), one or more reads of register 0 (polls), and a read of register 1 (data). It then pulses done with status 0 and the data read from register 1.
- R3: A write request produces, in order, a write of register 1 with req_wdata, a write of register 0 (command), and one or more polls of register 0. It then pulses done with status 0 and rdata 0. Every access uses the requested address.
- R4: The command word has bit 15 = 1 (busy), bit 12 = 1 (mode), bits 11:10 = 2'b10 for a read or 2'b01 for a write, bits 9:5 = device number, bits 4:0 = register number. Bits 14:13 are 0.
- R5: The first MIN_POLLS (2) polls are issued back to back: with an acknowledge in the cycle after each request, successive poll acknowledges are 2 cycles apart.
- R6: After the minimum attempts, each further poll follows a gap of GAP_MS*CLK_HZ/1000 cycles (at least 1), so poll acknowledges are 2 + gap cycles apart.
- R7: When busy is still set at the end of a gap and TIMEOUT_MS*CLK_HZ/1000 cycles have passed since polling began, done is pulsed with status 2 (timeout). No further bus access follows.
- R8: At least MIN_POLLS polls are made even if the budget has already expired during the first poll.
- R9: An access acknowledged with bus_err ends the sequence at once. done is pulsed with status 1 and rdata 0, and no further access is issued.
- R10: A request is accepted only while req_ready is 1. req_valid while busy has no effect. done is high for exactly one cycle per accepted request.
- R11: bus_req, once raised, stays high with unchanged address, register, direction and write data until bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while req_ready is high |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 5 | Strapped bus address of the remote device |
| req_dev | input | 5 | Internal device number |
| req_reg | input | 5 | Internal register number |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 bus error, 2 timeout; valid with done |
| rdata | output | 16 | Read data; valid with done |
| bus_req | output | 1 | Primitive access request, held until bus_ack |
| bus_write | output | 1 | Primitive access direction, 1 = write |
| bus_addr | output | 5 | Primitive access bus address |
| bus_reg | output | 5 | Primitive access register (0 command, 1 data) |
| bus_wdata | output | 16 | Primitive write data |
| bus_ack | input | 1 | One-cycle completion of the pending access |
| bus_err | input | 1 | Access failed; valid with bus_ack |
| bus_rdata | input | 16 | Primitive read data; valid with bus_ack |

## Verification
The assertions assume that the bus side raises bus_ack for a single cycle and only while bus_req is high, and that bus_err and bus_rdata count only in that cycle. The bench's remote-device model acknowledges only a pending request and drops the acknowledge in the next cycle. It can delay one chosen access, fail one chosen access, or hold busy for a set number of polls. All of these stay inside that contract. Requests are offered while the block is busy only on purpose, to show that they are ignored.

// File: rtl/ias_pkg.sv
package ias_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUT_DATA,
        ST_PUT_CMD,
        ST_POLL,
        ST_GAP,
        ST_GET_DATA,
        ST_FINISH
    } state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_BUS_ERR = 2'd1,
        RES_TIMEOUT = 2'd2
    } res_e;

    localparam logic [4:0] CMD_REG  = 5'd0;
    localparam logic [4:0] DATA_REG = 5'd1;
    localparam int         BUSY_BIT = 15;

endpackage

// File: rtl/ias_cmd_fmt.sv
module ias_cmd_fmt #(
    parameter int unsigned FW = 5
) (
    input  logic          is_write,
    input  logic [FW-1:0] dev,
    input  logic [FW-1:0] regn,
    output logic [15:0]   word
);
    localparam int PADW = 10 - 2 * FW;

    // busy, two spare zeros, mode select, opcode, device, register
    always_comb begin
        word        = '0;
        word[15]    = 1'b1;
        word[12]    = 1'b1;
        word[11:10] = is_write ? 2'b01 : 2'b10;
        word[9:0]   = {{PADW{1'b0}}, dev, regn};
    end
endmodule

// File: rtl/ias_poll_timer.sv
module ias_poll_timer #(
    parameter int unsigned BUDGET_CYC = 100,
    parameter int unsigned GAP_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic gap_run,
    output logic expired,
    output logic gap_done
);
    localparam int             BW   = $clog2(BUDGET_CYC + 1);
    localparam logic [BW-1:0]  BLIM = BW'(BUDGET_CYC);

    logic [BW-1:0] bcnt;

    // Budget counter: runs while polling, saturates at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            bcnt <= '0;
        else if (!run)         bcnt <= '0;
        else if (bcnt != BLIM) bcnt <= bcnt + 1'b1;
    end

    assign expired = (bcnt == BLIM);

    generate
        if (GAP_CYC <= 1) begin : g_short
            assign gap_done = gap_run;
        end else begin : g_count
            localparam int            GW    = $clog2(GAP_CYC);
            localparam logic [GW-1:0] GLAST = GW'(GAP_CYC - 1);
            logic [GW-1:0] gcnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        gcnt <= '0;
                else if (!gap_run) gcnt <= '0;
                else               gcnt <= gcnt + 1'b1;
            end

            assign gap_done = gap_run && (gcnt == GLAST);
        end
    endgenerate
endmodule

// File: rtl/ias_seq.sv
module ias_seq
    import ias_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 200_000_000,
    parameter int unsigned TIMEOUT_MS = 50,
    parameter int unsigned GAP_MS     = 1,
    parameter int unsigned MIN_POLLS  = 2,
    parameter logic [4:0]  INIT_ADDR  = 5'h10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [4:0]  req_addr,
    input  logic [4:0]  req_dev,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        done,
    output logic [1:0]  status,
    output logic [15:0] rdata,
    output logic        bus_req,
    output logic        bus_write,
    output logic [4:0]  bus_addr,
    output logic [4:0]  bus_reg,
    output logic [15:0] bus_wdata,
    input  logic        bus_ack,
    input  logic        bus_err,
    input  logic [15:0] bus_rdata
);
    localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
    localparam int unsigned BUDGET_CYC = CYC_PER_MS * TIMEOUT_MS;
    localparam int unsigned GAP_RAW    = CYC_PER_MS * GAP_MS;
    localparam int unsigned GAP_CYC    = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam int          PW         = $clog2(MIN_POLLS + 1);
    localparam logic [PW-1:0] PMIN     = PW'(MIN_POLLS);

    state_e        st, st_nx;
    res_e          res_q, res_nx;
    logic          res_set;
    logic          in_init;
    logic          l_write;
    logic [4:0]    l_addr, l_dev, l_reg;
    logic [15:0]   l_wdata;
    logic [PW-1:0] polls, polls_inc;
    logic [15:0]   rd_q;
    logic [15:0]   cmd_word;
    logic          t_expired, t_gap_done;
    logic          busy_seen;

    ias_cmd_fmt #(.FW(5)) u_fmt (
        .is_write (l_write),
        .dev      (l_dev),
        .regn     (l_reg),
        .word     (cmd_word)
    );

    ias_poll_timer #(.BUDGET_CYC(BUDGET_CYC), .GAP_CYC(GAP_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      ((st == ST_POLL) || (st == ST_GAP)),
        .gap_run  (st == ST_GAP),
        .expired  (t_expired),
        .gap_done (t_gap_done)
    );

    assign busy_seen = bus_rdata[BUSY_BIT];
    assign polls_inc = (polls == PMIN) ? polls : polls + 1'b1;

    // State register; reset enters the init poll pass
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_POLL;
        else        st <= st_nx;
    end

    // Next state and result selection
    always_comb begin
        st_nx   = st;
        res_nx  = RES_OK;
        res_set = 1'b0;
        unique case (st)
            ST_IDLE:
                if (req_valid) st_nx = req_write ? ST_PUT_DATA : ST_PUT_CMD;
            ST_PUT_DATA:
                if (bus_ack) begin
                    if (bus_err) begin st_nx = ST_FINISH; res_set = 1'b1; res_nx = RES_BUS_ERR; end
                    else         st_nx = ST_PUT_CMD;
                end
            ST_PUT_CMD:
                if (bus_ack) begin
                    if (bus_err) begin st_nx = ST_FINISH; res_set = 1'b1; res_nx = RES_BUS_ERR; end
                    else         st_nx = ST_POLL;
                end
            ST_POLL:
                if (bus_ack) begin
                    if (bus_err) begin
                        if (in_init) st_nx = ST_IDLE;
                        else begin st_nx = ST_FINISH; res_set = 1'b1; res_nx = RES_BUS_ERR; end
                    end else if (!busy_seen) begin
                        if (in_init)      st_nx = ST_IDLE;
                        else if (l_write) begin st_nx = ST_FINISH; res_set = 1'b1; res_nx = RES_OK; end
                        else              st_nx = ST_GET_DATA;
                    end else if (polls_inc < PMIN) begin
                        st_nx = ST_POLL;
                    end else begin
                        st_nx = ST_GAP;
                    end
                end
            ST_GAP:
                if (t_gap_done) begin
                    if (!t_expired)   st_nx = ST_POLL;
                    else if (in_init) st_nx = ST_IDLE;
                    else begin st_nx = ST_FINISH; res_set = 1'b1; res_nx = RES_TIMEOUT; end
                end
            ST_GET_DATA:
                if (bus_ack) begin
                    st_nx   = ST_FINISH;
                    res_set = 1'b1;
                    res_nx  = bus_err ? RES_BUS_ERR : RES_OK;
                end
            ST_FINISH:
                st_nx = ST_IDLE;
            default:
                st_nx = ST_IDLE;
        endcase
    end

    // Request latch, poll count and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_init <= 1'b1;
            l_write <= 1'b0;
            l_addr  <= INIT_ADDR;
            l_dev   <= '0;
            l_reg   <= '0;
            l_wdata <= '0;
            polls   <= '0;
            res_q   <= RES_OK;
            rd_q    <= '0;
        end else begin
            if (st == ST_IDLE && req_valid) begin
                l_write <= req_write;
                l_addr  <= req_addr;
                l_dev   <= req_dev;
                l_reg   <= req_reg;
                l_wdata <= req_wdata;
                polls   <= '0;
                res_q   <= RES_OK;
                rd_q    <= '0;
            end
            if (st != ST_IDLE && st_nx == ST_IDLE) in_init <= 1'b0;
            if (st == ST_POLL && bus_ack && !bus_err && busy_seen) polls <= polls_inc;
            if (res_set) res_q <= res_nx;
            if (st == ST_GET_DATA && bus_ack && !bus_err) rd_q <= bus_rdata;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready = (st == ST_IDLE);
        done      = (st == ST_FINISH);
        status    = res_q;
        rdata     = rd_q;
        bus_req   = (st == ST_PUT_DATA) || (st == ST_PUT_CMD) ||
                    (st == ST_POLL)     || (st == ST_GET_DATA);
        bus_write = (st == ST_PUT_DATA) || (st == ST_PUT_CMD);
        bus_addr  = l_addr;
        bus_reg   = ((st == ST_PUT_DATA) || (st == ST_GET_DATA)) ? DATA_REG : CMD_REG;
        if (st == ST_PUT_DATA)     bus_wdata = l_wdata;
        else if (st == ST_PUT_CMD) bus_wdata = cmd_word;
        else                       bus_wdata = '0;
    end
endmodule

// File: rtl/ias_seq_chk.sv
module ias_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        done,
    input logic [1:0]  status,
    input logic [15:0] rdata,
    input logic        bus_req,
    input logic        bus_write,
    input logic [4:0]  bus_addr,
    input logic [4:0]  bus_reg,
    input logic [15:0] bus_wdata,
    input logic        bus_ack,
    input logic        bus_err
);
    // R11
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_reg) &&
                                $stable(bus_write) && $stable(bus_wdata));

    // R9
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_err |=> !bus_req);

    // R9
    err_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && status != 2'd0 |-> rdata == 16'd0);

    // R10
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_req && !done);

    // R7
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status != 2'd3);

    // R4
    cmd_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_write && bus_reg == 5'd0 |-> bus_wdata[15] && bus_wdata[12] &&
                                                    bus_wdata[11:10] != 2'b00);

    // R11 (environment side of the handshake)
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> bus_req);
endmodule

bind ias_seq ias_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .status    (status),
    .rdata     (rdata),
    .bus_req   (bus_req),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_reg   (bus_reg),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err)
);

// File: tb/ias_seq_test.sv
module ias_seq_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int         CLK_HZ = 2000;
    localparam int         BUDGET = CLK_HZ / 1000 * 50;
    localparam int         GAP    = CLK_HZ / 1000 * 1;
    localparam logic [4:0] INIT_A = 5'h10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] req_addr = '0, req_dev = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic req_ready, done, bus_req, bus_write;
    logic [1:0] status;
    logic [15:0] rdata, bus_wdata;
    logic [4:0] bus_addr, bus_reg;
    logic bus_ack, bus_err;
    logic [15:0] bus_rdata;

    always #2.5 clk = ~clk;

    ias_seq #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(50), .GAP_MS(1), .MIN_POLLS(2), .INIT_ADDR(INIT_A)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_dev(req_dev), .req_reg(req_reg),
        .req_wdata(req_wdata), .done(done), .status(status), .rdata(rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    int nchk = 0, nerr = 0, ndone = 0, cyc = 0;

    // Remote device model and access log
    logic [15:0] mem [1024];
    logic [15:0] dreg;
    int busy_left, wcnt, acc_n;
    int busy_set = 1, err_idx = -1, slow_idx = -1, slow_lat = 0;
    bit          lw [512];
    logic [4:0]  la [512];
    logic [4:0]  lr [512];
    logic [15:0] ld [512];
    int          lc [512];

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
            wcnt <= 0; busy_left <= 3; dreg <= '0; acc_n <= 0;
            for (int i = 0; i < 1024; i++) mem[i] <= '0;
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
            if (bus_req && !bus_ack) begin
                if (wcnt < ((acc_n == slow_idx) ? slow_lat : 0)) begin
                    wcnt <= wcnt + 1;
                end else begin
                    wcnt <= 0;
                    bus_ack <= 1'b1;
                    lw[acc_n % 512] <= bus_write;
                    la[acc_n % 512] <= bus_addr;
                    lr[acc_n % 512] <= bus_reg;
                    ld[acc_n % 512] <= bus_wdata;
                    lc[acc_n % 512] <= cyc;
                    acc_n <= acc_n + 1;
                    if (acc_n == err_idx) begin
                        bus_err <= 1'b1;
                    end else if (bus_write) begin
                        if (bus_reg == 5'd1) dreg <= bus_wdata;
                        else if (bus_wdata[15]) begin
                            if (bus_wdata[11:10] == 2'b01) mem[bus_wdata[9:0]] <= dreg;
                            else if (bus_wdata[11:10] == 2'b10) dreg <= mem[bus_wdata[9:0]];
                            busy_left <= busy_set;
                        end
                    end else if (bus_reg == 5'd1) begin
                        bus_rdata <= dreg;
                    end else if (busy_left > 0) begin
                        bus_rdata <= 16'h8000;
                        busy_left <= busy_left - 1;
                    end else begin
                        bus_rdata <= 16'h0000;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_cmd(input bit w, input logic [4:0] d, input logic [4:0] r);
        return 16'h9000 | (w ? 16'h0400 : 16'h0800) | {6'd0, d, r};
    endfunction

    // Scoreboard
    typedef struct {
        logic [1:0]  st;
        logic [15:0] rd;
        string       tag;
    } exp_t;
    exp_t sb_q [$];

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) chk("R10 done without accepted request", 1, 0);
            else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " status"}, status, e.st);
                chk({e.tag, " rdata"}, rdata, e.rd);
            end
            ndone++;
        end
    end

    int base = 0;

    task automatic start_req(input bit w, input logic [4:0] a, input logic [4:0] d,
                             input logic [4:0] r, input logic [15:0] wd,
                             input logic [1:0] es, input logic [15:0] er, input string tag);
        exp_t e;
        while (!req_ready) @(negedge clk);
        base = acc_n;
        req_write = w; req_addr = a; req_dev = d; req_reg = r; req_wdata = wd;
        req_valid = 1'b1;
        e.st = es; e.rd = er; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int tgt;
        tgt = ndone + 1;
        while (ndone < tgt) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_req(input bit w, input logic [4:0] a, input logic [4:0] d,
                           input logic [4:0] r, input logic [15:0] wd,
                           input logic [1:0] es, input logic [15:0] er, input string tag);
        start_req(w, a, d, r, wd, es, er, tag);
        wait_done();
    endtask

    task automatic chk_acc(input int k, input bit w, input logic [4:0] a,
                           input logic [4:0] r, input string tag);
        chk({tag, " dir"},  lw[(base + k) % 512], w);
        chk({tag, " addr"}, la[(base + k) % 512], a);
        chk({tag, " reg"},  lr[(base + k) % 512], r);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired before the test sequence ended");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: init poll running, not ready
        chk("R1 ready low after reset", req_ready, 0);
        chk("R1 init poll request", bus_req, 1);
        chk("R1 init poll addr", bus_addr, INIT_A);
        while (!req_ready) @(negedge clk);
        chk("R1 init poll count", acc_n, 4);
        base = 0;
        chk_acc(3, 0, INIT_A, 5'd0, "R1 last init poll");
        chk("R1 no done in init", ndone, 0);

        // R3 R4: write sequence and command word
        run_req(1, 5'h04, 5'd3, 5'd7, 16'hA5A5, 2'd0, 16'h0, "R3 write");
        chk("R3 access count", acc_n - base, 4);
        chk_acc(0, 1, 5'h04, 5'd1, "R3 data first");
        chk("R3 data value", ld[base % 512], 16'hA5A5);
        chk_acc(1, 1, 5'h04, 5'd0, "R3 command second");
        chk("R4 write cmd word", ld[(base + 1) % 512], exp_cmd(1, 5'd3, 5'd7));
        chk_acc(2, 0, 5'h04, 5'd0, "R3 poll");

        // R2 R4: read sequence
        run_req(0, 5'h04, 5'd3, 5'd7, 16'h0, 2'd0, 16'hA5A5, "R2 read");
        chk("R2 access count", acc_n - base, 4);
        chk_acc(0, 1, 5'h04, 5'd0, "R2 command first");
        chk("R4 read cmd word", ld[base % 512], exp_cmd(0, 5'd3, 5'd7));
        chk_acc(2, 0, 5'h04, 5'd0, "R2 poll");
        chk_acc(3, 0, 5'h04, 5'd1, "R2 data last");

        // R2 R3 R4: second pattern at field extremes
        run_req(1, 5'h1E, 5'd31, 5'd31, 16'h1234, 2'd0, 16'h0, "R3 write max fields");
        chk("R4 max cmd word", ld[(base + 1) % 512], exp_cmd(1, 5'd31, 5'd31));
        run_req(0, 5'h1E, 5'd31, 5'd31, 16'h0, 2'd0, 16'h1234, "R2 read max fields");

        // R5 R6: poll spacing
        busy_set = 4;
        run_req(1, 5'h02, 5'd5, 5'd1, 16'h0F0F, 2'd0, 16'h0, "R6 long busy write");
        chk("R6 access count", acc_n - base, 7);
        chk("R5 back-to-back polls", lc[(base + 3) % 512] - lc[(base + 2) % 512], 2);
        chk("R6 gap before third poll", lc[(base + 4) % 512] - lc[(base + 3) % 512], 2 + GAP);
        chk("R6 gap before fourth poll", lc[(base + 5) % 512] - lc[(base + 4) % 512], 2 + GAP);

        // R7: timeout
        busy_set = 100000;
        run_req(0, 5'h02, 5'd5, 5'd1, 16'h0, 2'd2, 16'h0, "R7 timeout");
        chk("R7 at least two polls", (acc_n - base - 1) >= 2, 1);
        chk("R7 polls bounded by budget", (acc_n - base - 1) <= BUDGET / (2 + GAP) + 3, 1);
        begin
            int snap;
            snap = acc_n;
            repeat (10) @(negedge clk);
            chk("R7 no access after timeout", acc_n, snap);
        end

        // R8 R11: budget spent inside the first poll
        busy_set = 1;
        slow_lat = 150;
        slow_idx = acc_n + 1;
        start_req(0, 5'h04, 5'd3, 5'd7, 16'h0, 2'd0, 16'hA5A5, "R8 slow first poll");
        repeat (40) @(negedge clk);
        chk("R11 request held during wait", bus_req, 1);
        chk("R11 register held", bus_reg, 5'd0);
        chk("R11 address held", bus_addr, 5'h04);
        wait_done();
        chk("R8 second poll made", acc_n - base, 4);

        busy_set = 100000;
        slow_idx = acc_n + 1;
        run_req(0, 5'h04, 5'd3, 5'd7, 16'h0, 2'd2, 16'h0, "R8 slow then busy");
        chk("R8 exactly two polls", acc_n - base, 3);
        slow_idx = -1;
        busy_set = 1;

        // R9: bus errors at several points
        err_idx = acc_n;
        run_req(1, 5'h04, 5'd8, 5'd8, 16'hBEEF, 2'd1, 16'h0, "R9 error on data write");
        chk("R9 stop after first access", acc_n - base, 1);
        err_idx = acc_n + 1;
        run_req(0, 5'h04, 5'd3, 5'd7, 16'h0, 2'd1, 16'h0, "R9 error on poll");
        chk("R9 stop after poll", acc_n - base, 2);
        err_idx = acc_n + 3;
        run_req(0, 5'h04, 5'd3, 5'd7, 16'h0, 2'd1, 16'h0, "R9 error on data read");
        chk("R9 stop after data read", acc_n - base, 4);
        err_idx = -1;
        run_req(0, 5'h04, 5'd8, 5'd8, 16'h0, 2'd0, 16'h0, "R9 aborted write left no data");

        // R10: requests while busy are ignored
        start_req(0, 5'h04, 5'd9, 5'd2, 16'h0, 2'd0, 16'h0, "R10 read while offered");
        for (int i = 0; i < 3; i++) begin
            req_valid = 1'b1; req_write = 1'b1; req_dev = 5'd9; req_reg = 5'd2; req_wdata = 16'hFFFF;
            chk("R10 ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_done();
        repeat (5) @(negedge clk);
        chk("R10 one done per request", sb_q.size(), 0);
        run_req(0, 5'h04, 5'd9, 5'd2, 16'h0, 2'd0, 16'h0, "R10 ignored write had no effect");

        finish_run();
    end
endmodule